// File: doc/BRIEF.md
# Register File with Same-Cycle Write Bypass

This block is the general-purpose register file of a small pipelined processor. It holds eight 32-bit registers and offers two independent combinational read ports for the decode stage and one synchronous write port for the writeback stage. Register zero is hardwired to zero.

When decode reads a register in the same cycle that writeback is writing it, the read port returns the incoming write data instead of the stale stored value. This makes a write appear to complete before a read in the same cycle. Each read port does this with its own address comparator and result multiplexer, so no inverted-clock register file is needed and the whole block stays on one clock edge. Reads are purely combinational from the read address. A write takes effect at the rising clock edge when the write enable is high.

Top module: `regfile_bypass`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register, so that after reset all eight addresses read as zero on both ports.
- R2: With wr_en high at a rising edge and wr_addr not zero, wr_data is stored at wr_addr, and later reads of that address return it until it is written again.
- R3: When wr_en is high, wr_addr equals rd_addr_a and rd_addr_a is not zero, rd_data_a equals wr_data in that same cycle, before the edge that stores it.
- R4: Port B applies the same bypass rule as R3 using rd_addr_b and rd_data_b, independently of port A.
- R5: With wr_en low, both ports return only stored contents whatever wr_addr and wr_data carry, and no register changes at the edge.
- R6: Address 0 always reads as zero on both ports, including in a cycle that writes address 0 with wr_en high, and a write to address 0 stores nothing.
- R7: Both ports may target the same address or different addresses in one cycle; both may bypass at once, or one may bypass while the other returns a stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write enable for the writeback port |
| wr_addr | input | 3 | Destination register of the write |
| wr_data | input | 32 | Value to write |
| rd_addr_a | input | 3 | Read port A register address |
| rd_data_a | output | 32 | Read port A result, combinational |
| rd_addr_b | input | 3 | Read port B register address |
| rd_data_b | output | 32 | Read port B result, combinational |

## Verification
The assertions check on every cycle that each port forwards write data when its address matches an enabled, nonzero write target, and that address zero reads zero. They also check that a stored write shows up on the next cycle, that a held read address with no write gives a stable result, and that everything reads zero right after reset. Only the bench scenarios can show that a disabled write leaves the old contents in place, that writes to address zero are lost, and that the two ports bypass independently when they use distinct and shared addresses. The bench does this by reading back every register through the normal read ports after each such stimulus.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DATA_W = 32;
  parameter int unsigned RF_DEPTH  = 8;
  parameter int unsigned RF_RD_PORTS = 2;
endpackage

// File: rtl/rf_write_decode.sv
// One write strobe per writable register; slot zero has no strobe at all.
module rf_write_decode #(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_REGS)
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  output logic [NUM_REGS-1:1]   wr_sel
);
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
// Register array: slot zero is a constant, the rest load on their strobe.
module rf_storage #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:1] wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   regs_q [NUM_REGS]
);
  assign regs_q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_sel[i]) begin
        q <= wr_data;
      end
    end
    assign regs_q[i] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
// One read port: array select plus a same-cycle bypass of the write data.
module rf_read_port #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] regs_q [NUM_REGS],
  output logic [DATA_W-1:0] rd_data
);
  logic is_zero;
  logic fwd_hit;

  assign is_zero = (rd_addr == '0);
  assign fwd_hit = wr_en && (wr_addr == rd_addr) && !is_zero;

  always_comb begin
    if (is_zero) begin
      rd_data = '0;
    end else if (fwd_hit) begin
      rd_data = wr_data;
    end else begin
      rd_data = regs_q[rd_addr];
    end
  end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int unsigned NUM_REGS = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NPORTS  = rf_pkg::RF_RD_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [NUM_REGS-1:1] wr_sel;
  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [ADDR_W-1:0]   port_addr [NPORTS];
  logic [DATA_W-1:0]   port_data [NPORTS];

  rf_write_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .rd_addr (port_addr[p]),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .regs_q  (regs_q),
      .rd_data (port_data[p])
    );
  end

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((rd_data_a == '0 || (wr_en && wr_addr == rd_addr_a)) &&
                    (rd_data_b == '0 || (wr_en && wr_addr == rd_addr_b))));

  assert_store_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      (rd_addr_a != $past(wr_addr) || (wr_en && wr_addr == rd_addr_a) ||
       rd_data_a == $past(wr_data)));

  assert_bypass_a_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == rd_addr_a && rd_addr_a != '0) |-> rd_data_a == wr_data);

  assert_bypass_b_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == rd_addr_b && rd_addr_b != '0) |-> rd_data_b == wr_data);

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(wr_en) && !$past(rst) && rd_addr_a == $past(rd_addr_a))
      |-> $stable(rd_data_a));

  assert_zero_a_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> rd_data_a == '0);

  assert_zero_b_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> rd_data_b == '0);

  assert_shared_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |-> rd_data_a == rd_data_b);
endmodule

bind regfile_bypass rf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b)
);

// File: tb/regfile_bypass_tb.sv
module regfile_bypass_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    bit          on_b;
    logic [31:0] exp;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr_a = '0;
  logic [2:0]  rd_addr_b = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;

  logic [31:0] model [8];
  exp_item_t   sb_q [$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_bypass u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  function automatic logic [31:0] predict(input logic [2:0] a, input bit we,
                                          input logic [2:0] wa, input logic [31:0] wd);
    if (a == 3'd0) return 32'd0;
    if (we && wa == a) return wd;
    return model[a];
  endfunction

  // Driver: one cycle of stimulus, expectations pushed to the scoreboard.
  task automatic apply(input bit we, input logic [2:0] wa, input logic [31:0] wd,
                       input logic [2:0] ra, input logic [2:0] rb, input string tag);
    exp_item_t ia, ib;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    ia.tag = tag; ia.on_b = 1'b0; ia.exp = predict(ra, we, wa, wd);
    ib.tag = tag; ib.on_b = 1'b1; ib.exp = predict(rb, we, wa, wd);
    sb_q.push_back(ia);
    sb_q.push_back(ib);
    if (we && wa != 3'd0) model[wa] = wd;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++) apply(1'b0, 3'd0, 32'd0, 3'(i), 3'(7 - i), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
  endtask

  // Monitor: compare every queued expectation a quarter period after the driver.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.on_b ? rd_data_b : rd_data_a;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port %s: actual %h expected %h",
                   it.tag, it.on_b ? "B" : "A", act, it.exp);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    read_all("R1 after reset");

    // Fill r1..r7; port A bypasses the target, port B reads r0.
    for (int i = 1; i < 8; i++)
      apply(1'b1, 3'(i), 32'hA5A0_0000 + 32'(i * 17), 3'(i), 3'd0, "R3 fill bypass");
    read_all("R2 readback");

    // Port B bypass while A reads a stored register.
    apply(1'b1, 3'd5, 32'h0BAD_F00D, 3'd2, 3'd5, "R4 bypass on B");
    // Both ports bypass the same target.
    apply(1'b1, 3'd3, 32'h1234_5678, 3'd3, 3'd3, "R7 dual bypass");
    // One bypasses, the other reads a distinct register.
    apply(1'b1, 3'd6, 32'hCAFE_0006, 3'd6, 3'd1, "R7 split ports");
    read_all("R2 after overwrites");

    // Disabled write with matching addresses: no bypass, no store.
    apply(1'b0, 3'd4, 32'hDEAD_BEEF, 3'd4, 3'd4, "R5 no bypass");
    apply(1'b0, 3'd7, 32'hFFFF_FFFF, 3'd7, 3'd2, "R5 no bypass");
    read_all("R5 contents kept");

    // Write to register zero: reads zero, nothing stored.
    apply(1'b1, 3'd0, 32'h7777_7777, 3'd0, 3'd0, "R6 zero bypass");
    read_all("R6 zero kept");

    // Back-to-back writes to one register, read on the next cycle.
    apply(1'b1, 3'd2, 32'h0000_0001, 3'd1, 3'd2, "R3 chain");
    apply(1'b1, 3'd2, 32'h0000_0002, 3'd2, 3'd2, "R3 chain");
    apply(1'b0, 3'd0, 32'd0, 3'd2, 3'd2, "R2 last write wins");

    do_reset();
    read_all("R1 mid-run reset");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule